// File: doc/BRIEF.md
# Byte-Lane Static RAM Emulator

This block is a synthesizable stand-in for a 16-bit wide asynchronous static RAM. It sits inside a clocked design and sees the memory's pins as ordinary inputs: an active-low chip select, a read-drive enable, a write strobe, two active-low byte-lane strobes and a word address. The bidirectional data pins are split into an input bus, an output bus and one drive-enable bit for each byte lane. A fast internal clock samples all of these pins every cycle. The block decodes the control combination, stores only the byte lanes that take part in a write, and drives each lane of the output on its own or leaves it undriven.

A write begins only when chip select, the write strobe and a lane strobe are all active together. It ends as soon as any one of them is released. The emulator commits a lane's byte on the clock edge whose sample first shows that lane's overlap has ended. The byte written is the one sampled on the last clock of the overlap, at the address sampled on that same clock. Because of this, the write strobe may stay low across several words while the lane strobes alone frame each word. Reads follow the sampled address combinationally from the stored words. The full part has a 16-bit address; a smaller address width keeps simulation light.

Top module: `lane_sram_emu`

## Requirements
- R1: While the sampled chip select is high, both bits of `dq_oe` are 0, whatever the other controls are, and no lane is written.
- R2: With chip select low, write strobe high and read-drive enable high, both bits of `dq_oe` are 0.
- R3: With chip select low and both lane strobes high, both bits of `dq_oe` are 0. No lane is written, even when the write strobe is low.
- R4: A read (chip select low, write strobe high, read-drive enable low) drives lane 0, which is bits 7..0 gated by `lb_n`, only when `lb_n` is low. It drives lane 1, which is bits 15..8 gated by `ub_n`, only when `ub_n` is low. Each driven lane carries the stored byte of the sampled address.
- R5: A write takes place whenever chip select and the write strobe are low, whatever the level of `oe_n`. While the sampled write strobe is low, both bits of `dq_oe` are 0.
- R6: A write changes only the lanes whose strobe is low. The stored byte of the other lane stays unchanged.
- R7: A lane's byte is committed on the rising edge whose sample first shows the overlap ended. The overlap may end through chip select, write strobe or lane strobe. The value stored is the data and address sampled on the last clock of the overlap, so a data change during the overlap leaves the last value.
- R8: With the write strobe held low, each low period of the lane strobes writes one word at the address held during that period.
- R9: A lane whose `dq_oe` bit is 0 shows 0 on its `dq_out` bits.
- R10: Outputs reflect the pins sampled at the previous rising edge. A read issued in the same cycle that a write overlap ends, at that address, returns the new data.
- R11: During and right after synchronous reset the sampled controls read as deselected, so both bits of `dq_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read-drive enable, active low |
| we_n | input | 1 | Write strobe, active low |
| ub_n | input | 1 | Upper lane (bits 15..8) strobe, active low |
| lb_n | input | 1 | Lower lane (bits 7..0) strobe, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data arriving at the pins |
| dq_out | output | 16 | Data the emulator would drive |
| dq_oe | output | 2 | Per-lane drive enable, bit 0 lower, bit 1 upper |

## Verification
Every pin is registered once, so a drive-enable and read-data result is due on the first rising edge after a stimulus. The bench changes pins on the falling edge and compares outputs on the next falling edge, half a cycle after that result appears. A write commits on the edge that samples the end of the overlap, which is the same edge that samples a following read, so a read placed right after the closing step already sees the new bytes. The behavioural reference repeats these rules for every clock, applying commits before it updates its sampled pin copy, and the directed steps read back partial-lane, late-data and strobe-framed writes.

// File: rtl/lane_sram_pkg.sv
// Shared constants, control bundle and decode helpers for the byte-lane
// static RAM emulator. Assumes two 8-bit lanes; lane 0 is bits 7..0.
package lane_sram_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    // Sampled control pins, all active low.
    typedef struct packed {
        logic             ce_n;
        logic             oe_n;
        logic             we_n;
        logic [LANES-1:0] lane_n;
    } pin_ctrl_t;

    localparam pin_ctrl_t CTRL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                        lane_n: {LANES{1'b1}}};

    // Lanes inside a write overlap: select, write strobe and lane strobe all low.
    function automatic logic [LANES-1:0] lane_wr_active(input pin_ctrl_t c);
        lane_wr_active = {LANES{~c.ce_n & ~c.we_n}} & ~c.lane_n;
    endfunction

    // Lanes to drive for a read: select low, write strobe high, read-drive low.
    function automatic logic [LANES-1:0] lane_rd_active(input pin_ctrl_t c);
        lane_rd_active = {LANES{~c.ce_n & c.we_n & ~c.oe_n}} & ~c.lane_n;
    endfunction

endpackage

// File: rtl/lsr_pin_sampler.sv
// Registers every emulated pin once on the fast clock.
// Assumes pins are already synchronous to clk; reset forces a deselected view.
module lsr_pin_sampler
    import lane_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pin_ctrl_t         ctrl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output pin_ctrl_t         ctrl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    // Sample stage: one register per pin, deselected under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            ctrl_q <= ctrl_i;
            addr_q <= addr_i;
            data_q <= data_i;
        end
    end

endmodule

// File: rtl/lsr_lane_decode.sv
// Decodes the sampled control bundle into per-lane read drive and write
// overlap flags. Purely combinational.
module lsr_lane_decode
    import lane_sram_pkg::*;
(
    input  pin_ctrl_t        ctrl,
    output logic [LANES-1:0] rd_en,
    output logic [LANES-1:0] wr_act
);

    // Truth-table decode per lane.
    always_comb begin
        rd_en  = lane_rd_active(ctrl);
        wr_act = lane_wr_active(ctrl);
    end

endmodule

// File: rtl/lsr_lane_store.sv
// Storage for one byte lane: one synchronous write port, one asynchronous
// read port. Contents are not reset, as in a real static RAM.
module lsr_lane_store #(
    parameter int ADDR_W = 8,
    parameter int WIDTH  = 8
) (
    input  logic              clk,
    input  logic              wen,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] cells [DEPTH];

    // Commit port: one byte per enabled clock.
    always_ff @(posedge clk) begin
        if (wen) begin
            cells[waddr] <= wdata;
        end
    end

    // Read port follows the address combinationally.
    assign rdata = cells[raddr];

endmodule

// File: rtl/lane_sram_emu.sv
// Byte-lane static RAM emulator top. Samples the RAM pins, commits a lane's
// byte on the edge whose sample first shows that lane's write overlap ended,
// and drives each output lane independently. Assumes ADDR_W kept small for
// simulation (16 for the full-size part).
module lane_sram_emu
    import lane_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe
);

    pin_ctrl_t         raw_ctrl;
    pin_ctrl_t         smp_ctrl;
    logic [ADDR_W-1:0] smp_addr;
    logic [DATA_W-1:0] smp_data;
    logic [LANES-1:0]  rd_en;
    logic [LANES-1:0]  was_wr;
    logic [LANES-1:0]  now_wr;
    logic [LANES-1:0]  commit;
    logic [DATA_W-1:0] rd_word;

    // Bundle the raw control pins; lane 1 is the upper strobe.
    always_comb begin
        raw_ctrl.ce_n   = ce_n;
        raw_ctrl.oe_n   = oe_n;
        raw_ctrl.we_n   = we_n;
        raw_ctrl.lane_n = {ub_n, lb_n};
    end

    lsr_pin_sampler #(.ADDR_W(ADDR_W)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_i (raw_ctrl),
        .addr_i (addr),
        .data_i (dq_in),
        .ctrl_q (smp_ctrl),
        .addr_q (smp_addr),
        .data_q (smp_data)
    );

    lsr_lane_decode u_decode (
        .ctrl   (smp_ctrl),
        .rd_en  (rd_en),
        .wr_act (was_wr)
    );

    // Overlap end detect: active on the last sample, inactive at the pins now.
    always_comb begin
        now_wr = lane_wr_active(raw_ctrl);
        commit = rst_n ? (was_wr & ~now_wr) : '0;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lsr_lane_store #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_store (
            .clk   (clk),
            .wen   (commit[g]),
            .waddr (smp_addr),
            .wdata (smp_data[g*LANE_W +: LANE_W]),
            .raddr (smp_addr),
            .rdata (rd_word[g*LANE_W +: LANE_W])
        );

        // Output lane: stored byte when driven, zero when released.
        always_comb begin
            dq_out[g*LANE_W +: LANE_W] = rd_en[g] ? rd_word[g*LANE_W +: LANE_W] : '0;
            dq_oe[g]                   = rd_en[g];
        end
    end

endmodule

// File: rtl/lane_sram_chk.sv
// Property checker for lane_sram_emu, attached by bind. Relates the pins
// sampled one edge earlier to the per-lane drive enables and output bytes.
module lane_sram_chk #(
    parameter int ADDR_W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        ub_n,
    input logic        lb_n,
    input logic [15:0] dq_out,
    input logic [1:0]  dq_oe
);

    // R1: a deselected sample leaves both lanes released.
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ce_n)) |-> (dq_oe == 2'b00));

    // R2: read-drive enable high with write strobe high releases both lanes.
    a_r2_oe_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ce_n) && $past(we_n) && $past(oe_n)) |-> (dq_oe == 2'b00));

    // R3: both lane strobes high releases both lanes.
    a_r3_no_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ub_n) && $past(lb_n)) |-> (dq_oe == 2'b00));

    // R4: during a read each lane follows its own strobe.
    a_r4_lane_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ce_n) && $past(we_n) && !$past(oe_n))
        |-> (dq_oe == {!$past(ub_n), !$past(lb_n)}));

    // R5: a low write strobe never drives the outputs.
    a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(we_n)) |-> (dq_oe == 2'b00));

    // R9: released lanes show zero.
    a_r9_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!dq_oe[0] |-> (dq_out[7:0] == 8'h00)) and (!dq_oe[1] |-> (dq_out[15:8] == 8'h00)));

    // R11: the edge after a reset edge still shows released lanes.
    a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dq_oe == 2'b00));

endmodule

bind lane_sram_emu lane_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .ub_n   (ub_n),
    .lb_n   (lb_n),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
);

// File: tb/tb_lane_sram_emu.sv
// Self-checking bench: a behavioural reference updated on each rising edge
// and compared on each falling edge, plus directed read-back steps.
module tb_lane_sram_emu;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int DEPTH      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          p_ce = 1'b1, p_oe = 1'b1, p_we = 1'b1, p_ub = 1'b1, p_lb = 1'b1;
    logic [AW-1:0] p_addr = '0;
    logic [15:0]   p_din = '0;
    logic [15:0]   dq_out;
    logic [1:0]    dq_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state: stored words, lane-valid flags, last sampled pins.
    logic [15:0]   ref_mem [DEPTH];
    logic [1:0]    ref_vld [DEPTH];
    logic          m_ce = 1'b1, m_oe = 1'b1, m_we = 1'b1;
    logic [1:0]    m_lane = 2'b11;
    logic [AW-1:0] m_addr = '0;
    logic [15:0]   m_din = '0;
    bit            mon_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_sram_emu #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(p_ce), .oe_n(p_oe), .we_n(p_we),
        .ub_n(p_ub), .lb_n(p_lb), .addr(p_addr), .dq_in(p_din),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = '0;
            ref_vld[i] = '0;
        end
    end

    // Reference update: commit ended overlaps (R7), then take a new sample.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ce = 1'b1; m_oe = 1'b1; m_we = 1'b1; m_lane = 2'b11;
            m_addr = '0; m_din = '0;
        end else begin
            for (int l = 0; l < 2; l++) begin
                bit was_on, is_on;
                was_on = !m_ce && !m_we && !m_lane[l];
                is_on  = !p_ce && !p_we && !(l == 0 ? p_lb : p_ub);
                if (was_on && !is_on) begin
                    ref_mem[m_addr][l*8 +: 8] = m_din[l*8 +: 8];
                    ref_vld[m_addr][l] = 1'b1;
                end
            end
            m_ce = p_ce; m_oe = p_oe; m_we = p_we; m_lane = {p_ub, p_lb};
            m_addr = p_addr; m_din = p_din;
        end
    end

    // Per-clock comparison against the reference (R1, R2, R4, R5, R9).
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            logic [1:0] e_oe;
            string tag;
            e_oe = (!m_ce && m_we && !m_oe) ? ~m_lane : 2'b00;
            if (m_ce)       tag = "R1";
            else if (!m_we) tag = "R5";
            else if (m_oe)  tag = "R2";
            else            tag = "R4";
            checks++;
            if (dq_oe !== e_oe) begin
                failures++;
                $display("FAIL %s dq_oe actual=%b expected=%b", tag, dq_oe, e_oe);
            end
            for (int l = 0; l < 2; l++) begin
                logic [7:0] e_b;
                bit known;
                known = !e_oe[l] || ref_vld[m_addr][l];
                e_b   = e_oe[l] ? ref_mem[m_addr][l*8 +: 8] : 8'h00;
                if (known) begin
                    checks++;
                    if (dq_out[l*8 +: 8] !== e_b) begin
                        failures++;
                        $display("FAIL %s lane%0d actual=%h expected=%h",
                                 e_oe[l] ? "R4" : "R9", l, dq_out[l*8 +: 8], e_b);
                    end
                end
            end
        end
    end

    // Set the pins at a falling edge and hold them for one clock.
    task automatic drive(input logic ce, input logic oe, input logic we,
                         input logic ub, input logic lb,
                         input logic [AW-1:0] a, input logic [15:0] d);
        p_ce = ce; p_oe = oe; p_we = we; p_ub = ub; p_lb = lb;
        p_addr = a; p_din = d;
        @(negedge clk);
    endtask

    // Compare both outputs with directly computed values.
    task automatic expect_out(input string tag, input logic [1:0] e_oe,
                              input logic [15:0] e_dat);
        checks++;
        if (dq_oe !== e_oe || dq_out !== e_dat) begin
            failures++;
            $display("FAIL %s actual oe=%b dat=%h expected oe=%b dat=%h",
                     tag, dq_oe, dq_out, e_oe, e_dat);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 16'h0000);
    endtask

    task automatic idle();
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, 16'h0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs released during reset
        expect_out("R11", 2'b00, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R11", 2'b00, 16'h0000);
        mon_on = 1;

        // R4: full word written, then read back
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5, 16'h1234);
        idle();
        rd(8'd5);
        expect_out("R4", 2'b11, 16'h1234);

        // R6: lower lane only, upper byte kept
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd5, 16'h99AB);
        idle();
        rd(8'd5);
        expect_out("R6", 2'b11, 16'h12AB);
        // R6: upper lane only, lower byte kept
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd5, 16'hCD77);
        idle();
        rd(8'd5);
        expect_out("R6", 2'b11, 16'hCDAB);

        // R4 / R9: read with only the lower strobe, then only the upper
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd5, 16'h0000);
        expect_out("R9", 2'b01, 16'h00AB);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd5, 16'h0000);
        expect_out("R4", 2'b10, 16'hCD00);

        // R5: write with read-drive enable low; outputs stay released
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9, 16'h5555);
        expect_out("R5", 2'b00, 16'h0000);
        idle();
        rd(8'd9);
        expect_out("R5", 2'b11, 16'h5555);

        // R7: data changes inside the overlap, ended by lane strobes
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd10, 16'h1111);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd10, 16'h2222);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd10, 16'h3333);
        idle();
        rd(8'd10);
        expect_out("R7", 2'b11, 16'h2222);
        // R7: overlap ended by chip select
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd11, 16'hA5A5);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd11, 16'h0F0F);
        rd(8'd11);
        expect_out("R7", 2'b11, 16'hA5A5);

        // R8: write strobe held low, lane strobes frame two words
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd20, 16'hBEEF);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd21, 16'h0000);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd21, 16'hCAFE);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd22, 16'h0000);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd22, 16'h0000);
        rd(8'd20);
        expect_out("R8", 2'b11, 16'hBEEF);
        rd(8'd21);
        expect_out("R8", 2'b11, 16'hCAFE);

        // R10: read issued in the cycle the overlap ends sees the new word
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd30, 16'h7E81);
        rd(8'd30);
        expect_out("R10", 2'b11, 16'h7E81);

        // R3: write strobe low but no lane strobe: nothing written
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd5, 16'hFFFF);
        expect_out("R3", 2'b00, 16'h0000);
        idle();
        rd(8'd5);
        expect_out("R3", 2'b11, 16'hCDAB);

        // R1: deselected write attempt: outputs released, nothing written
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5, 16'h0000);
        expect_out("R1", 2'b00, 16'h0000);
        idle();
        rd(8'd5);
        expect_out("R1", 2'b11, 16'hCDAB);

        // R2: read-drive enable high during a read
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd5, 16'h0000);
        expect_out("R2", 2'b00, 16'h0000);

        // Mixed traffic on a few addresses, checked by the reference each clock
        for (int n = 0; n < 800; n++) begin
            logic [4:0] r;
            r = 5'($urandom);
            drive(r[0] & r[1], r[2], $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
                  $urandom_range(0, 2) == 0, AW'($urandom_range(0, 7)), 16'($urandom));
        end
        idle();
        idle();
        finish_run();
    end

endmodule